// File: doc/BRIEF.md
# Byte-Fed CRC-16 Check Engine

This block computes a 16-bit frame check sequence for an infrared serial link, one byte at a time, under register control. Software first clears the engine through a control register. It then writes each frame byte into a data-input register, one byte per write. At any time it can read back two values: how many bytes have been absorbed, and the running check value.

The checksum uses the CCITT polynomial x^16 + x^12 + x^5 + 1 in its bit-reflected form, with an all-ones seed and an all-ones final inversion. Each byte is folded into the state in a single clock through a parallel eight-step update. The seed, inversion mask and bit order are package parameters. As a self-test, software can reset the engine, feed four known bytes, and compare the count and the result against fixed expected values.

Top module: `crc16_frame_engine`

## Requirements
- R1: After the synchronous reset input, the control register (address 0) reads 0x0000 and the result register (address 2) reads 0x0000, because the seed 0xFFFF is inverted on readout.
- R2: A write to the control register with bit 15 set sets the absorbed-byte count to 0 and returns the CRC state to its seed, so the result register reads 0x0000 afterwards.
- R3: A write to the control register with bit 15 clear leaves both the count and the CRC unchanged.
- R4: Each write to the data register (address 1) absorbs only bits 7:0 of the write data and increments the count by one; bits 15:8 have no effect on the result.
- R5: After a reset followed by the bytes 0xCC, 0xF5, 0xF1 and 0xA7 in that order, the control register reads 4 and the result register reads 0x51DF.
- R6: A read of the result register in the cycle after a data write returns the CRC already updated with that byte.
- R7: The count saturates at 0xFFF; further data writes keep it at 0xFFF and still update the CRC.
- R8: Control reads return the count in bits 11:0 and zero in bits 15:12. Address 3 reads 0x0000. Writes to the result register or to address 3 change neither the count nor the CRC.
- R9: For any byte sequence, the result equals the reflected CCITT CRC with polynomial constant 0x8408, seed 0xFFFF and final XOR 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Register select: 0 control, 1 data in, 2 result, 3 unused |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register that addr selects, combinational |

## Verification
The assertions assume that `wr_en` is a single-cycle strobe with a stable `addr` and `wdata`, and that the bus never writes and resets in the same cycle. The stimulus drives every input on the falling clock edge and releases `wr_en` one cycle later. Reads are made by holding `addr` while `wr_en` is low and sampling away from the rising edge. Because the read path is combinational, a value sampled in the cycle after a write already reflects that write.

// File: rtl/crc16_engine_pkg.sv
package crc16_engine_pkg;

    localparam int REG_W   = 16;
    localparam int ADDR_W  = 2;
    localparam int CNT_W   = 12;
    localparam int BYTE_W  = 8;

    localparam logic [REG_W-1:0] CRC_SEED    = 16'hFFFF;
    localparam logic [REG_W-1:0] CRC_XOROUT  = 16'hFFFF;
    localparam logic [REG_W-1:0] POLY_NORMAL = 16'h1021;
    localparam logic [REG_W-1:0] POLY_REFL   = 16'h8408;
    localparam bit               CRC_REFLECT = 1'b1;
    localparam int               FLUSH_BIT   = 15;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DIN   = 2'd1,
        SEL_DOUT  = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic flush;
        logic absorb;
    } engine_cmd_t;

    function automatic logic [REG_W-1:0] crc_fold_byte(
        input logic [REG_W-1:0]  state,
        input logic [BYTE_W-1:0] data,
        input bit                reflect
    );
        logic [REG_W-1:0] s;
        s = state;
        if (reflect) begin
            s = s ^ {{(REG_W-BYTE_W){1'b0}}, data};
            for (int i = 0; i < BYTE_W; i++)
                s = s[0] ? ((s >> 1) ^ POLY_REFL) : (s >> 1);
        end else begin
            s = s ^ {data, {(REG_W-BYTE_W){1'b0}}};
            for (int i = 0; i < BYTE_W; i++)
                s = s[REG_W-1] ? ((s << 1) ^ POLY_NORMAL) : (s << 1);
        end
        return s;
    endfunction

endpackage

// File: rtl/crc16_cmd_decode.sv
module crc16_cmd_decode
    import crc16_engine_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output engine_cmd_t       cmd
);
    always_comb begin
        cmd = '0;
        if (wr_en) begin
            unique case (reg_sel_e'(addr))
                SEL_CTRL: cmd.flush  = wdata[FLUSH_BIT];
                SEL_DIN:  cmd.absorb = 1'b1;
                default:  cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/crc16_state_reg.sv
module crc16_state_reg
    import crc16_engine_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  engine_cmd_t       cmd,
    input  logic [BYTE_W-1:0] data_byte,
    output logic [REG_W-1:0]  state_q
);
    logic [REG_W-1:0] state_d;

    always_comb begin
        state_d = state_q;
        if (cmd.flush)
            state_d = CRC_SEED;
        else if (cmd.absorb)
            state_d = crc_fold_byte(state_q, data_byte, CRC_REFLECT);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= CRC_SEED;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/crc16_absorb_counter.sv
module crc16_absorb_counter
    import crc16_engine_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  engine_cmd_t      cmd,
    output logic [CNT_W-1:0] count_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || cmd.flush)
            count_q <= '0;
        else if (cmd.absorb && count_q != CNT_MAX)
            count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/crc16_frame_engine.sv
module crc16_frame_engine
    import crc16_engine_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata
);
    engine_cmd_t      cmd;
    logic [REG_W-1:0] crc_state;
    logic [CNT_W-1:0] absorb_cnt;

    crc16_cmd_decode u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    crc16_state_reg u_state (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .data_byte (wdata[BYTE_W-1:0]),
        .state_q   (crc_state)
    );

    crc16_absorb_counter u_count (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .count_q (absorb_cnt)
    );

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_CTRL: rdata = {{(REG_W-CNT_W){1'b0}}, absorb_cnt};
            SEL_DOUT: rdata = crc_state ^ CRC_XOROUT;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc16_frame_engine_chk.sv
module crc16_frame_engine_chk
    import crc16_engine_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  crc_state,
    input logic [CNT_W-1:0]  absorb_cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    p_flush_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_CTRL && wdata[FLUSH_BIT])
        |=> (absorb_cnt == '0 && crc_state == CRC_SEED));

    p_ctrl_noop_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_CTRL && !wdata[FLUSH_BIT])
        |=> ($stable(absorb_cnt) && $stable(crc_state)));

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_DIN && absorb_cnt != CNT_TOP)
        |=> (absorb_cnt == $past(absorb_cnt) + 1'b1));

    p_count_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_DIN && absorb_cnt == CNT_TOP)
        |=> (absorb_cnt == CNT_TOP));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ($stable(absorb_cnt) && $stable(crc_state)));

    p_dead_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == SEL_DOUT || addr == SEL_SPARE))
        |=> ($stable(absorb_cnt) && $stable(crc_state)));
endmodule

bind crc16_frame_engine crc16_frame_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .crc_state  (crc_state),
    .absorb_cnt (absorb_cnt)
);

// File: tb/crc16_frame_engine_test.sv
module crc16_frame_engine_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] model_state;
    int          model_count;

    crc16_frame_engine uut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] ref_bitwise(input logic [15:0] s, input logic [7:0] b);
        logic [15:0] r;
        r = s;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ b[k]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 16'h0000;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic feed(input logic [15:0] d);
        bus_write(2'd1, d);
        model_state = ref_bitwise(model_state, d[7:0]);
        if (model_count < 4095) model_count++;
    endtask

    task automatic flush_model();
        bus_write(2'd0, 16'h8000);
        model_state = 16'hFFFF;
        model_count = 0;
    endtask

    task automatic expect_both(input string req);
        logic [15:0] v;
        bus_read(2'd0, v);
        check(req, v, 16'(model_count));
        bus_read(2'd2, v);
        check(req, v, model_state ^ 16'hFFFF);
    endtask

    task automatic t_reset_state();
        expect_both("R1");
    endtask

    task automatic t_check_vector();
        logic [15:0] v;
        flush_model();
        feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
        bus_read(2'd0, v); check("R5", v, 16'd4);
        bus_read(2'd2, v); check("R5", v, 16'h51DF);
    endtask

    task automatic t_flush();
        logic [15:0] v;
        feed(16'h0012);
        bus_write(2'd0, 16'h8000);
        bus_read(2'd0, v); check("R2", v, 16'h0000);
        bus_read(2'd2, v); check("R2", v, 16'h0000);
        model_state = 16'hFFFF; model_count = 0;
    endtask

    task automatic t_ctrl_noop();
        feed(16'h0055); feed(16'h00AA);
        bus_write(2'd0, 16'h7FFF);
        expect_both("R3");
    endtask

    task automatic t_upper_ignored();
        logic [15:0] v;
        flush_model();
        feed(16'hFF3C);
        bus_read(2'd2, v);
        check("R4", v, ref_bitwise(16'hFFFF, 8'h3C) ^ 16'hFFFF);
        bus_read(2'd0, v); check("R4", v, 16'd1);
    endtask

    task automatic t_next_cycle_read();
        logic [15:0] v;
        flush_model();
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd1; wdata = 16'h0077;
        @(negedge clk);
        wr_en = 1'b0;
        addr = 2'd2; #1;
        v = rdata;
        model_state = ref_bitwise(model_state, 8'h77); model_count = 1;
        check("R6", v, model_state ^ 16'hFFFF);
    endtask

    task automatic t_dead_writes();
        logic [15:0] v;
        feed(16'h0091);
        bus_write(2'd2, 16'h1234);
        bus_write(2'd3, 16'hFFFF);
        expect_both("R8");
        bus_read(2'd3, v); check("R8", v, 16'h0000);
    endtask

    task automatic t_random_frames();
        flush_model();
        for (int i = 0; i < 40; i++) feed(16'((i * 37 + 11) & 16'hFF));
        expect_both("R9");
        flush_model();
        for (int i = 0; i < 9; i++) feed(16'(8'hFF - i));
        expect_both("R9");
    endtask

    task automatic t_saturate();
        logic [15:0] v;
        flush_model();
        for (int i = 0; i < 4100; i++) feed(16'(i & 16'hFF));
        bus_read(2'd0, v); check("R7", v, 16'h0FFF);
        bus_read(2'd2, v); check("R7", v, model_state ^ 16'hFFFF);
        expect_both("R8");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = 16'h0000;
        model_state = 16'hFFFF; model_count = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_check_vector();
        t_flush();
        t_ctrl_noop();
        t_upper_ignored();
        t_next_cycle_read();
        t_dead_writes();
        t_random_frames();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule